// File: doc/BRIEF.md
# Edge Pulse Counter

This block counts transitions of an external pulse pin in a signed register. The pulse pin and a direction-control pin are asynchronous to the block clock. Each pin passes through a multi-flop synchronizer before any edge is detected. Two 2-bit settings choose the action for each kind of edge: count up, count down, or ignore. Two more 2-bit settings choose how the synchronized control level changes that action: leave it as set, invert its direction, or suppress it.

The count moves between a programmable signed upper and lower bound. A step that would go past a bound returns the count to zero and raises a one-cycle event flag. Three single-cycle commands act on the running counter. One freezes the count, one zeroes it, and one lets counting continue from the held value. The count is always visible on an output port.

Top module: `edge_pulse_counter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `count_o` is 0 and `limit_evt_o` is 0. The counter leaves reset in the running state.
- R2: A rising pulse edge acts according to `rise_mode`: 2'b01 steps the count by +1, 2'b10 by -1, and 2'b00 or 2'b11 leaves it unchanged. The new count appears after the third rising clock edge following the pin change.
- R3: A falling pulse edge acts according to `fall_mode`, with the same encoding and latency as R2.
- R4: While the synchronized control pin is low, `ctrl_lo_mode` applies: 2'b00 keeps the edge action, 2'b01 inverts its direction, and 2'b10 or 2'b11 suppresses it.
- R5: While the synchronized control pin is high, `ctrl_hi_mode` applies, with the encoding of R4.
- R6: An up step taken when the count is at or above `limit_hi` sets the count to 0. `limit_evt_o` is high for exactly that cycle.
- R7: A down step taken when the count is at or below `limit_lo` sets the count to 0. `limit_evt_o` is high for exactly that cycle.
- R8: One cycle after `cmd_pause`, the count no longer changes for pulse edges until a resume.
- R9: After `cmd_resume`, counting continues from the held value.
- R10: `cmd_clear` sets the count to 0 on the next clock edge. It wins over a step consumed at that edge, and it does not change the running or paused state.
- R11: When `cmd_pause` and `cmd_resume` are high in the same cycle, the counter becomes paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pulse_in | input | 1 | Asynchronous pulse pin whose edges are counted |
| ctrl_in | input | 1 | Asynchronous control pin that selects the level mode |
| rise_mode | input | 2 | Action on a rising pulse edge |
| fall_mode | input | 2 | Action on a falling pulse edge |
| ctrl_lo_mode | input | 2 | Modifier applied while the control pin is low |
| ctrl_hi_mode | input | 2 | Modifier applied while the control pin is high |
| limit_hi | input | CNT_W | Signed upper bound |
| limit_lo | input | CNT_W | Signed lower bound |
| cmd_pause | input | 1 | Single-cycle command to freeze counting |
| cmd_clear | input | 1 | Single-cycle command to zero the count |
| cmd_resume | input | 1 | Single-cycle command to restart counting |
| count_o | output | CNT_W | Signed current count |
| limit_evt_o | output | 1 | One-cycle flag for a wrap at a bound |

## Verification
A pin change takes three rising clock edges to reach the count: two synchronizer flops, then the count register. The bench therefore drives each pin on a falling edge and reads the count on the third falling edge afterwards. The wrap flag is due on that same edge and must be low on the next falling edge, so it is sampled on both. Commands take effect on the next rising edge: a clear is checked one falling edge after it is raised, and a pause is judged only by edges that arrive after that. Before any pulses are sent, the control pin is held for several cycles so that its level has settled through the synchronizer.

// File: rtl/epc_pkg.sv
package epc_pkg;
   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_UP   = 2'b01,
      EDGE_DOWN = 2'b10,
      EDGE_RSVD = 2'b11
   } edge_act_e;

   typedef enum logic [1:0] {
      LVL_KEEP  = 2'b00,
      LVL_FLIP  = 2'b01,
      LVL_HOLD  = 2'b10,
      LVL_RSVD  = 2'b11
   } lvl_act_e;

   typedef struct packed {
      logic up;
      logic dn;
   } step_t;
endpackage

// File: rtl/epc_sync.sv
module epc_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o
);
   logic [STAGES-1:0][W-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else        stage_q <= {stage_q[STAGES-2:0], async_i};
   end

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/epc_step_dec.sv
module epc_step_dec
   import epc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        pulse_s,
   input  logic        ctrl_s,
   input  logic [1:0]  rise_mode,
   input  logic [1:0]  fall_mode,
   input  logic [1:0]  lo_mode,
   input  logic [1:0]  hi_mode,
   output step_t       step_o
);
   logic      prev_q;
   logic      rise_w, fall_w;
   edge_act_e act_w;
   lvl_act_e  lvl_w;
   logic      base_up, base_dn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= pulse_s;
   end

   assign rise_w = pulse_s & ~prev_q;
   assign fall_w = ~pulse_s & prev_q;

   always_comb begin
      if (rise_w)      act_w = edge_act_e'(rise_mode);
      else if (fall_w) act_w = edge_act_e'(fall_mode);
      else             act_w = EDGE_NONE;
      lvl_w   = ctrl_s ? lvl_act_e'(hi_mode) : lvl_act_e'(lo_mode);
      base_up = (act_w == EDGE_UP);
      base_dn = (act_w == EDGE_DOWN);
      case (lvl_w)
         LVL_KEEP: step_o = '{up: base_up, dn: base_dn};
         LVL_FLIP: step_o = '{up: base_dn, dn: base_up};
         default:  step_o = '{up: 1'b0,    dn: 1'b0};
      endcase
   end
endmodule

// File: rtl/epc_count_core.sv
module epc_count_core
   import epc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  step_t                   step_i,
   input  logic                    pause_i,
   input  logic                    clear_i,
   input  logic                    resume_i,
   input  logic signed [CNT_W-1:0] hi_i,
   input  logic signed [CNT_W-1:0] lo_i,
   output logic signed [CNT_W-1:0] count_o,
   output logic                    evt_o
);
   logic run_q;
   logic at_hi, at_lo;

   assign at_hi = (count_o >= hi_i);
   assign at_lo = (count_o <= lo_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        run_q <= 1'b1;
      else if (pause_i)  run_q <= 1'b0;
      else if (resume_i) run_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_o <= '0;
         evt_o   <= 1'b0;
      end else if (clear_i) begin
         count_o <= '0;
         evt_o   <= 1'b0;
      end else if (run_q && step_i.up) begin
         count_o <= at_hi ? '0 : count_o + 1'b1;
         evt_o   <= at_hi;
      end else if (run_q && step_i.dn) begin
         count_o <= at_lo ? '0 : count_o - 1'b1;
         evt_o   <= at_lo;
      end else begin
         evt_o   <= 1'b0;
      end
   end
endmodule

// File: rtl/edge_pulse_counter.sv
module edge_pulse_counter
   import epc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    pulse_in,
   input  logic                    ctrl_in,
   input  logic [1:0]              rise_mode,
   input  logic [1:0]              fall_mode,
   input  logic [1:0]              ctrl_lo_mode,
   input  logic [1:0]              ctrl_hi_mode,
   input  logic signed [CNT_W-1:0] limit_hi,
   input  logic signed [CNT_W-1:0] limit_lo,
   input  logic                    cmd_pause,
   input  logic                    cmd_clear,
   input  logic                    cmd_resume,
   output logic signed [CNT_W-1:0] count_o,
   output logic                    limit_evt_o
);
   localparam int PIN_W = 2;

   generate
      if (CNT_W < 4) begin : g_bad_width
         $error("edge_pulse_counter: CNT_W must be at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("edge_pulse_counter: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [PIN_W-1:0] pins_s;
   step_t            step_w;

   epc_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({ctrl_in, pulse_in}),
      .sync_o  (pins_s)
   );

   epc_step_dec dec_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pulse_s   (pins_s[0]),
      .ctrl_s    (pins_s[1]),
      .rise_mode (rise_mode),
      .fall_mode (fall_mode),
      .lo_mode   (ctrl_lo_mode),
      .hi_mode   (ctrl_hi_mode),
      .step_o    (step_w)
   );

   epc_count_core #(.CNT_W(CNT_W)) core_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_i   (step_w),
      .pause_i  (cmd_pause),
      .clear_i  (cmd_clear),
      .resume_i (cmd_resume),
      .hi_i     (limit_hi),
      .lo_i     (limit_lo),
      .count_o  (count_o),
      .evt_o    (limit_evt_o)
   );
endmodule

// File: rtl/epc_checker.sv
module epc_checker #(
   parameter int CNT_W = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cmd_pause,
   input logic                    cmd_clear,
   input logic signed [CNT_W-1:0] count_o,
   input logic                    limit_evt_o
);
   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_clear |=> (count_o == '0)); // R10

   AST_EVT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      limit_evt_o |-> (count_o == '0)); // R6

   AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_pause ##1 !cmd_clear |=> $stable(count_o)); // R8

   AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ((count_o != $past(count_o)) && (count_o != '0)) |->
         (((count_o - $past(count_o)) == CNT_W'(1)) ||
          ((count_o - $past(count_o)) == {CNT_W{1'b1}}))); // R2
endmodule

bind edge_pulse_counter epc_checker #(.CNT_W(CNT_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_pause   (cmd_pause),
   .cmd_clear   (cmd_clear),
   .count_o     (count_o),
   .limit_evt_o (limit_evt_o)
);

// File: tb/edge_pulse_counter_tb_top.sv
`timescale 1ns/1ps
module edge_pulse_counter_tb_top;
   localparam int CW = 16;
   localparam int NV = 13;
   // {rise, fall, lo, hi, ctrl}
   localparam logic [8:0] VEC [NV] = '{
      {2'b01, 2'b00, 2'b00, 2'b00, 1'b1},
      {2'b10, 2'b00, 2'b00, 2'b00, 1'b1},
      {2'b00, 2'b01, 2'b00, 2'b00, 1'b1},
      {2'b01, 2'b01, 2'b00, 2'b00, 1'b1},
      {2'b01, 2'b10, 2'b00, 2'b00, 1'b1},
      {2'b01, 2'b00, 2'b01, 2'b00, 1'b0},
      {2'b01, 2'b00, 2'b00, 2'b01, 1'b0},
      {2'b01, 2'b00, 2'b10, 2'b00, 1'b0},
      {2'b10, 2'b00, 2'b01, 2'b00, 1'b0},
      {2'b01, 2'b00, 2'b00, 2'b10, 1'b1},
      {2'b01, 2'b00, 2'b00, 2'b01, 1'b1},
      {2'b11, 2'b11, 2'b00, 2'b00, 1'b1},
      {2'b01, 2'b00, 2'b11, 2'b00, 1'b0}
   };
   localparam int EXP [NV] = '{1, -1, 1, 2, 0, -1, 1, 0, 1, 0, -1, 0, 0};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pulse_in = 1'b0, ctrl_in = 1'b1;
   logic [1:0] rise_mode = 2'b01, fall_mode = 2'b00, lo_mode = 2'b00, hi_mode = 2'b00;
   logic signed [CW-1:0] limit_hi = 16'sd10000, limit_lo = -16'sd10000;
   logic cmd_pause = 1'b0, cmd_clear = 1'b0, cmd_resume = 1'b0;
   logic signed [CW-1:0] count_o;
   logic limit_evt_o;
   int tests = 0, fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   edge_pulse_counter #(.CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .ctrl_in(ctrl_in),
      .rise_mode(rise_mode), .fall_mode(fall_mode),
      .ctrl_lo_mode(lo_mode), .ctrl_hi_mode(hi_mode),
      .limit_hi(limit_hi), .limit_lo(limit_lo),
      .cmd_pause(cmd_pause), .cmd_clear(cmd_clear), .cmd_resume(cmd_resume),
      .count_o(count_o), .limit_evt_o(limit_evt_o));

   task automatic check(string tag, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // drive pin, then the count is due on the third falling edge after
   task automatic rise_edge();
      @(negedge clk); pulse_in = 1'b1; idle(3);
   endtask
   task automatic fall_edge();
      @(negedge clk); pulse_in = 1'b0; idle(3);
   endtask
   task automatic pulses(int n);
      for (int i = 0; i < n; i++) begin rise_edge(); fall_edge(); end
   endtask
   task automatic do_clear();
      @(negedge clk); cmd_clear = 1'b1; @(negedge clk); cmd_clear = 1'b0;
   endtask
   task automatic do_cmd(bit p, bit r);
      @(negedge clk); cmd_pause = p; cmd_resume = r;
      @(negedge clk); cmd_pause = 1'b0; cmd_resume = 1'b0;
   endtask

   initial begin
      #800000;
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      idle(3);
      check("R1 count in reset", int'(count_o), 0);
      check("R1 evt in reset", int'(limit_evt_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 count after reset", int'(count_o), 0);
      check("R1 evt after reset", int'(limit_evt_o), 0);

      // table walk over R2 R3 R4 R5 encodings
      for (int v = 0; v < NV; v++) begin
         {rise_mode, fall_mode, lo_mode, hi_mode, ctrl_in} = VEC[v];
         idle(5);
         do_clear();
         pulses(3);
         check($sformatf("R2/R3/R4/R5 vector %0d", v), int'(count_o), 3 * EXP[v]);
      end

      // R6 upper wrap
      rise_mode = 2'b01; fall_mode = 2'b00; lo_mode = 2'b00; hi_mode = 2'b00;
      ctrl_in = 1'b1; limit_hi = 16'sd5; limit_lo = -16'sd3;
      idle(5); do_clear();
      pulses(5);
      check("R6 at upper bound", int'(count_o), 5);
      rise_edge();
      check("R6 wrap count", int'(count_o), 0);
      check("R6 evt raised", int'(limit_evt_o), 1);
      @(negedge clk);
      check("R6 evt one cycle", int'(limit_evt_o), 0);
      fall_edge();

      // R7 lower wrap
      rise_mode = 2'b10;
      idle(2); do_clear();
      pulses(3);
      check("R7 at lower bound", int'(count_o), -3);
      rise_edge();
      check("R7 wrap count", int'(count_o), 0);
      check("R7 evt raised", int'(limit_evt_o), 1);
      @(negedge clk);
      check("R7 evt one cycle", int'(limit_evt_o), 0);
      fall_edge();

      // R8 pause, R9 resume
      rise_mode = 2'b01; limit_hi = 16'sd10000; limit_lo = -16'sd10000;
      idle(2); do_clear();
      pulses(2);
      do_cmd(1'b1, 1'b0);
      pulses(3);
      check("R8 paused count held", int'(count_o), 2);
      do_cmd(1'b0, 1'b1);
      pulses(2);
      check("R9 resumed from held value", int'(count_o), 4);

      // R10 clear collides with a counted edge
      @(negedge clk); pulse_in = 1'b1;
      idle(1);
      @(negedge clk); cmd_clear = 1'b1;
      @(negedge clk); cmd_clear = 1'b0;
      check("R10 clear wins over edge", int'(count_o), 0);
      idle(4);
      check("R10 edge not counted later", int'(count_o), 0);
      fall_edge();
      pulses(1);
      check("R10 clear keeps running state", int'(count_o), 1);

      // R11 pause and resume together
      do_cmd(1'b1, 1'b1);
      pulses(2);
      check("R11 pause wins", int'(count_o), 1);
      do_cmd(1'b0, 1'b1);
      pulses(1);
      check("R9 resume after R11", int'(count_o), 2);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule